// File: doc/BRIEF.md
# Flagged 8-bit ALU

This block is the arithmetic and logic unit of a small accumulator machine. It takes two 8-bit operands, a primary operand and a secondary operand, and a 4-bit operation code. It produces an 8-bit result that feeds the accumulator register. For each operation it also works out carry, zero and sign flags. Every operation has its own rule for each flag: the flag is computed from the operation, forced to a constant, or left as it was.

The accumulator and the three flags are registers inside the block. They change only on a rising clock edge while the commit input is high. Operation codes that are not assigned leave the accumulator and all three flags unchanged. The registered values are the block's outputs, so a result can be seen one cycle after its operation is committed.

Top module: `flag_alu`

## Requirements
- R1: After reset (rstN low), accResult is 0 and carryFlag, zeroFlag and signFlag are all 0.
- R2: While commitEn is low, accResult and the three flags keep their values, whatever opSel and the operands are.
- R3: Code 0 gives srcB AND srcC, code 1 gives srcB OR srcC, and code 7 gives NOT srcB. For all three, carry is forced to 0, and zero and sign are computed from the result.
- R4: Code 2 shifts srcB left by one place, with 0 entering bit 0. Carry takes the old bit 7 of srcB, and zero and sign are computed from the result.
- R5: Code 3 shifts srcB right by one place, with 0 entering bit 7. Carry takes the old bit 0 of srcB, zero is computed from the result, and sign is forced to 0.
- R6: Code 4 gives srcB + srcC and code 5 gives srcB + 1, both taken modulo 256. Carry is the carry out of bit 7, and zero and sign are computed from the result.
- R7: Code 6 gives srcB - 1 modulo 256. Carry is 1 exactly when srcB was 0 (a borrow), and zero and sign are computed from the result.
- R8: Code 8 writes 0 to the accumulator and sets carry to 0, zero to 1 and sign to 0.
- R9: Codes 9 through 15 leave the accumulator and all three flags unchanged, even when commitEn is high.
- R10: Wherever zero is computed, it is 1 exactly when the 8-bit result is 0. Wherever sign is computed, it equals bit 7 of the result.
- R11: A committed operation shows up on the outputs one clock after the edge on which commitEn was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| commitEn | input | 1 | Commits the result and flags on the next edge |
| opSel | input | 4 | Operation code |
| srcB | input | 8 | Primary operand |
| srcC | input | 8 | Secondary operand |
| accResult | output | 8 | Registered accumulator |
| carryFlag | output | 1 | Registered carry flag |
| zeroFlag | output | 1 | Registered zero flag |
| signFlag | output | 1 | Registered sign flag |

## Verification
The hardest case to see at the ports is an unassigned code, or a cleared commit, leaving a flag alone. That only shows if the flag already holds a value the operation would otherwise have changed. The stimulus therefore first sets the flags to non-default values, for example a carry of 1 from 0xFF+1 or a sign of 1 from a NOT, and then applies an unassigned code or a low commit. The model compares every flag on the next cycle. Edge operands such as 0x00, 0x80, 0xFF and 0x01 are mixed into random sequences, so that the borrow on decrement, the carry out of a shift and wrap-around to zero all occur.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0, OP_OR = 4'd1, OP_SHL = 4'd2, OP_SHR = 4'd3,
    OP_ADD = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_NOT = 4'd7,
    OP_CLR = 4'd8
  } aluOpE;

  typedef enum logic [1:0] {
    FL_KEEP = 2'd0, FL_CALC = 2'd1, FL_ZERO = 2'd2, FL_ONE = 2'd3
  } flagRuleE;

  typedef struct packed {
    logic     writeAcc;
    flagRuleE carryRule;
    flagRuleE zeroRule;
    flagRuleE signRule;
  } aluStrobeT;
endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           commitEn,
  input  logic [OPW-1:0] opSel,
  output aluStrobeT      strobe
);
  always_comb begin
    strobe = '{writeAcc: 1'b0, carryRule: FL_KEEP, zeroRule: FL_KEEP, signRule: FL_KEEP};
    if (commitEn) begin
      case (opSel)
        OP_AND, OP_OR, OP_NOT:
          strobe = '{writeAcc: 1'b1, carryRule: FL_ZERO, zeroRule: FL_CALC, signRule: FL_CALC};
        OP_SHR:
          strobe = '{writeAcc: 1'b1, carryRule: FL_CALC, zeroRule: FL_CALC, signRule: FL_ZERO};
        OP_SHL, OP_ADD, OP_INC, OP_DEC:
          strobe = '{writeAcc: 1'b1, carryRule: FL_CALC, zeroRule: FL_CALC, signRule: FL_CALC};
        OP_CLR:
          strobe = '{writeAcc: 1'b1, carryRule: FL_ZERO, zeroRule: FL_ONE, signRule: FL_ZERO};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  aluStrobeT      strobe,
  input  logic [OPW-1:0] opSel,
  input  logic [DW-1:0]  srcB,
  input  logic [DW-1:0]  srcC,
  output logic [DW-1:0]  accQ,
  output logic           carryQ,
  output logic           zeroQ,
  output logic           signQ
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] resNext;
  logic          carryCalc;
  logic [DW:0]   wideSum;

  always_comb begin
    resNext   = '0;
    carryCalc = 1'b0;
    wideSum   = '0;
    case (opSel)
      OP_AND: resNext = srcB & srcC;
      OP_OR:  resNext = srcB | srcC;
      OP_NOT: resNext = ~srcB;
      OP_SHL: begin resNext = {srcB[MSB-1:0], 1'b0}; carryCalc = srcB[MSB]; end
      OP_SHR: begin resNext = {1'b0, srcB[MSB:1]};   carryCalc = srcB[0];   end
      OP_ADD: begin
        wideSum   = {1'b0, srcB} + {1'b0, srcC};
        resNext   = wideSum[DW-1:0];
        carryCalc = wideSum[DW];
      end
      OP_INC: begin
        wideSum   = {1'b0, srcB} + {1'b0, ONE};
        resNext   = wideSum[DW-1:0];
        carryCalc = wideSum[DW];
      end
      OP_DEC: begin
        resNext   = srcB - ONE;
        carryCalc = (srcB == '0);
      end
      default: resNext = '0;
    endcase
  end

  function automatic logic applyRule(flagRuleE rule, logic cur, logic calc);
    case (rule)
      FL_CALC: return calc;
      FL_ZERO: return 1'b0;
      FL_ONE:  return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      carryQ <= 1'b0;
      zeroQ  <= 1'b0;
      signQ  <= 1'b0;
    end else begin
      if (strobe.writeAcc) accQ <= resNext;
      carryQ <= applyRule(strobe.carryRule, carryQ, carryCalc);
      zeroQ  <= applyRule(strobe.zeroRule,  zeroQ,  (resNext == '0));
      signQ  <= applyRule(strobe.signRule,  signQ,  resNext[MSB]);
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           commitEn,
  input  logic [OPW-1:0] opSel,
  input  logic [DW-1:0]  srcB,
  input  logic [DW-1:0]  srcC,
  output logic [DW-1:0]  accResult,
  output logic           carryFlag,
  output logic           zeroFlag,
  output logic           signFlag
);
  aluStrobeT strobe;

  flag_alu_ctrl #(.OPW(OPW)) uCtrl (
    .commitEn(commitEn), .opSel(opSel), .strobe(strobe)
  );

  flag_alu_dp #(.DW(DW), .OPW(OPW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSel(opSel),
    .srcB(srcB), .srcC(srcC),
    .accQ(accResult), .carryQ(carryFlag), .zeroQ(zeroFlag), .signQ(signFlag)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DW  = 8,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           commitEn,
  input logic [OPW-1:0] opSel,
  input logic [DW-1:0]  srcB,
  input logic [DW-1:0]  accResult,
  input logic           carryFlag,
  input logic           zeroFlag,
  input logic           signFlag
);
  logic idle;
  assign idle = !commitEn || (opSel > OPW'(8));

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> $stable({accResult, carryFlag, zeroFlag, signFlag})); // R2

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (commitEn && opSel == OPW'(8)) |=> (accResult == '0 && !carryFlag && zeroFlag && !signFlag)); // R8

  AST_SHR_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (commitEn && opSel == OPW'(3)) |=> (!signFlag && accResult[DW-1] == 1'b0)); // R5

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (commitEn && (opSel == OPW'(0) || opSel == OPW'(1) || opSel == OPW'(7))) |=> !carryFlag); // R3

  AST_DEC_BORROW: assert property (@(posedge clk) disable iff (!rstN)
    (commitEn && opSel == OPW'(6)) |=> (carryFlag == ($past(srcB) == '0))); // R7

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (commitEn && opSel < OPW'(8)) |=> (zeroFlag == (accResult == '0))); // R10
endmodule

bind flag_alu flag_alu_chk #(.DW(DW), .OPW(OPW)) uChk (
  .clk(clk), .rstN(rstN), .commitEn(commitEn), .opSel(opSel), .srcB(srcB),
  .accResult(accResult), .carryFlag(carryFlag), .zeroFlag(zeroFlag), .signFlag(signFlag)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       commitEn = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] srcB = '0, srcC = '0;
  logic [7:0] accResult;
  logic       carryFlag, zeroFlag, signFlag;

  int checks = 0, fails = 0;
  int mAcc = 0, mC = 0, mZ = 0, mN = 0;
  bit done = 0;

  flag_alu dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(string req);
    checks++;
    if (accResult !== 8'(mAcc) || carryFlag !== 1'(mC) || zeroFlag !== 1'(mZ) || signFlag !== 1'(mN)) begin
      fails++;
      $display("FAIL %s op=%0d b=%02h c=%02h: actual acc=%02h c=%0b z=%0b n=%0b expected acc=%02h c=%0d z=%0d n=%0d",
               req, opSel, srcB, srcC, accResult, carryFlag, zeroFlag, signFlag, mAcc, mC, mZ, mN);
    end
  endtask

  // behavioural model of one committed operation
  task automatic model(int op, int b, int c, bit en);
    int r;
    if (!en || op > 8) return;
    case (op)
      0: begin r = b & c;      mC = 0; end
      1: begin r = b | c;      mC = 0; end
      7: begin r = (~b) & 255; mC = 0; end
      2: begin r = (b * 2) & 255; mC = (b >= 128); end
      3: begin r = b / 2;      mC = b % 2; end
      4: begin r = (b + c) % 256; mC = (b + c) > 255; end
      5: begin r = (b + 1) % 256; mC = (b == 255); end
      6: begin r = (b + 255) % 256; mC = (b == 0); end
      default: begin mAcc = 0; mC = 0; mZ = 1; mN = 0; return; end
    endcase
    mAcc = r;
    mZ = (r == 0);
    mN = (op == 3) ? 0 : (r >= 128);
  endtask

  function automatic string reqOf(int op, bit en);
    if (!en) return "R2";
    case (op)
      0, 1, 7: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // apply between edges, compare after the next edge (R11 one-cycle latency)
  task automatic step(int op, int b, int c, bit en, string tag = "");
    @(negedge clk);
    opSel = 4'(op); srcB = 8'(b); srcC = 8'(c); commitEn = en;
    model(op, b, c, en);
    @(negedge clk);
    compare(tag != "" ? tag : reqOf(op, en));
  endtask

  initial begin
    int edges[6] = '{0, 1, 127, 128, 254, 255};
    repeat (2) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    // R11: latency check, outputs unchanged before the edge
    @(negedge clk);
    opSel = 4'd4; srcB = 8'd5; srcC = 8'd6; commitEn = 1'b1;
    #1 compare("R11");
    model(4, 5, 6, 1);
    @(negedge clk);
    compare("R11");
    step(4, 255, 1, 1, "R6");      // carry 1, zero 1 (R10)
    step(9, 3, 3, 1, "R9");        // flags held at c1 z1
    step(7, 0, 0, 1, "R3");        // sign 1
    step(15, 0, 0, 1, "R9");
    step(0, 1, 2, 0, "R2");        // held
    step(6, 0, 0, 1, "R7");        // borrow
    step(12, 0, 0, 1, "R9");
    step(3, 1, 0, 1, "R5");        // carry 1, zero 1
    step(2, 128, 0, 1, "R4");
    step(8, 77, 9, 1, "R8");
    step(5, 255, 0, 1, "R6");
    step(5, 127, 0, 1, "R10");
    foreach (edges[i]) foreach (edges[j])
      for (int op = 0; op < 16; op++) step(op, edges[i], edges[j], 1);
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 3) != 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule